// File: doc/BRIEF.md
# Receive Byte-to-Word Packer with Buffer Close

This block sits behind a serial receiver and in front of software that reads 32-bit words. Received bytes are gathered into a 32-bit word, first byte in the lowest lane. A word goes to a 16-word (64-byte) receive FIFO once four bytes are in it. A buffer-close event forces it out earlier. Such an event is either an end-of-frame pulse from the receiver or a close requested by software. Each FIFO word carries a valid-byte count (1 to 4) and a flag marking the last word of a buffer.

Software requests a close through a request bit that hardware clears on its own once the close is done. A 2-bit output shows how many bytes are waiting in the packer. A flush level empties the FIFO and the packer. A completed word that cannot enter a full FIFO waits in a one-word holding stage. While it waits, the block reports a stall and drops further bytes, and a sticky overflow flag records each drop.

Top module: `rx_word_packer`

## Requirements
- R1: While `rx_en` is 0, `byte_valid` and `frame_end` have no effect: `pend_cnt` stays unchanged and no word is written.
- R2: Bytes fill lanes in arrival order: byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16, byte 3 in 31:24. A word of four bytes without a close has `rd_nbytes`=4 and `rd_last`=0. It becomes readable two clock edges after its last byte is taken.
- R3: `pend_cnt` gives the number of accepted bytes not yet moved into a word, 0 to 3, and reads 0 right after a word is formed.
- R4: `frame_end` (with `rx_en`=1) closes the buffer. If it comes with a byte, that byte is included. The pending bytes form one word in the low lanes with the unused lanes zero, `rd_nbytes` set to the count and `rd_last`=1. With nothing pending, nothing is written.
- R5: A one-cycle pulse on `sw_close` sets `close_pend` after that edge. At the following edge the pending bytes are closed out as in R4 and `close_pend` returns to 0. With no bytes pending, no word is written and the bit still clears.
- R6: The FIFO returns words first-in first-out. `rd_valid` is 1 while it holds a word. A `rd_pop` pulse removes the head word. `fifo_full` is 1 when it holds 16 words.
- R7: When a formed word cannot enter the full FIFO, `stall` is 1. Bytes arriving while `stall` is 1 are dropped without changing `pend_cnt`, and `overflow` becomes 1 and stays 1 until flush or reset. After a pop, the held word enters the FIFO and `stall` falls.
- R8: While `flush` is 1, the FIFO is empty, `pend_cnt` is 0, `close_pend` and `overflow` are 0, and incoming bytes are ignored.
- R9: After reset, `pend_cnt`, `close_pend`, `rd_valid`, `fifo_full`, `stall` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| frame_end | input | 1 | End-of-frame close event |
| sw_close | input | 1 | Software close request pulse |
| flush | input | 1 | Flush level for FIFO and packer |
| rd_pop | input | 1 | Remove head word from FIFO |
| close_pend | output | 1 | Software close request bit, self-clearing |
| pend_cnt | output | 2 | Bytes waiting in the packer |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_data | output | 32 | Head word data |
| rd_nbytes | output | 3 | Valid bytes in head word (1 to 4) |
| rd_last | output | 1 | Head word closes a buffer |
| fifo_full | output | 1 | FIFO holds 16 words |
| stall | output | 1 | Formed word blocked by a full FIFO |
| overflow | output | 1 | Sticky: a byte was dropped |

## Verification
The assertions check rules that must hold on every cycle. The FIFO is never written while full. A flush always leaves it empty. A disabled receiver or a stall never moves the pending count. A formed word with fewer than four bytes always carries the last flag. A software close request always clears one cycle after it is served. What only the bench scenarios can show is the data itself. That means the lane order of real byte streams, the counts and flags of frames from one to nine bytes closed either with the final byte or by a separate pulse, and the exact word order through a full FIFO and the held seventeenth word. It also includes the loss of exactly the bytes sent during a stall.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int NB_W   = $clog2(LANES + 1);
  localparam int CNT_W  = $clog2(LANES);

  typedef struct packed {
    logic              last;
    logic [NB_W-1:0]   nbytes;
    logic [WORD_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/rxp_close_ctrl.sv
module rxp_close_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic sw_close,
  input  logic close_ack,
  output logic close_pend
);
  always_ff @(posedge clk) begin
    if (rst || flush)   close_pend <= 1'b0;
    else if (sw_close)  close_pend <= 1'b1;
    else if (close_ack) close_pend <= 1'b0;
  end
endmodule

// File: rtl/rxp_lane_packer.sv
module rxp_lane_packer
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rx_en,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_end,
  input  logic              close_pend,
  input  logic              fifo_full,
  output rx_word_t          hold_q,
  output logic              fifo_wr,
  output logic              close_ack,
  output logic              stall,
  output logic              overflow,
  output logic [CNT_W-1:0]  pend_cnt
);
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q, acc_nx;
  logic              hold_v_q;
  logic              live, take, closing, emit, drop;
  logic [NB_W-1:0]   new_n;

  always_comb begin
    stall     = hold_v_q & fifo_full;
    fifo_wr   = hold_v_q & ~fifo_full;
    live      = ~flush & ~stall;
    take      = live & rx_en & byte_valid;
    closing   = live & ((rx_en & frame_end) | close_pend);
    close_ack = live & close_pend;
    drop      = ~flush & stall & rx_en & byte_valid;
    new_n     = {1'b0, cnt_q} + NB_W'(take);
    acc_nx    = acc_q;
    for (int l = 0; l < LANES; l++) begin
      if (take && cnt_q == CNT_W'(l)) acc_nx[l*BYTE_W +: BYTE_W] = byte_data;
    end
    emit = (closing | (take & (cnt_q == CNT_W'(LANES-1)))) & (new_n != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      overflow <= 1'b0;
    end else begin
      if (emit) begin
        hold_q.last   <= closing;
        hold_q.nbytes <= new_n;
        hold_q.data   <= acc_nx;
        hold_v_q      <= 1'b1;
        cnt_q         <= '0;
        acc_q         <= '0;
      end else begin
        hold_v_q <= stall;
        if (take) begin
          cnt_q <= cnt_q + 1'b1;
          acc_q <= acc_nx;
        end
      end
      if (drop) overflow <= 1'b1;
    end
  end

  assign pend_cnt = cnt_q;

  AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !close_pend && !flush) |=> $stable(cnt_q)); // R1
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> $stable(cnt_q)); // R7
  AST_PARTIAL_IS_LAST: assert property (@(posedge clk) disable iff (rst)
    (hold_v_q && hold_q.nbytes != NB_W'(LANES)) |-> hold_q.last); // R4
  AST_NBYTES_NONZERO: assert property (@(posedge clk) disable iff (rst)
    hold_v_q |-> (hold_q.nbytes != '0)); // R2
endmodule

// File: rtl/rxp_word_fifo.sv
module rxp_word_fifo
  import rxp_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     wr_en,
  input  rx_word_t wdata,
  input  logic     rd_pop,
  output rx_word_t rdata,
  output logic     not_empty,
  output logic     full
);
  localparam int AW = $clog2(WORDS);

  rx_word_t    mem [WORDS];
  logic [AW:0] wptr, rptr;
  logic        wr_ok, rd_ok;

  assign full      = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign not_empty = (wptr != rptr);
  assign wr_ok     = wr_en & ~full & ~flush;
  assign rd_ok     = rd_pop & not_empty & ~flush;
  assign rdata     = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> !not_empty); // R8
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rxp_pkg::*;
#(
  parameter int FIFO_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_end,
  input  logic              sw_close,
  input  logic              flush,
  input  logic              rd_pop,
  output logic              close_pend,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [NB_W-1:0]   rd_nbytes,
  output logic              rd_last,
  output logic              fifo_full,
  output logic              stall,
  output logic              overflow
);
  localparam int WORDS = FIFO_BYTES / LANES;

  rx_word_t hold_w, head_w;
  logic     fifo_wr, close_ack;

  rxp_close_ctrl u_close (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .sw_close   (sw_close),
    .close_ack  (close_ack),
    .close_pend (close_pend)
  );

  rxp_lane_packer u_pack (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .rx_en      (rx_en),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_end  (frame_end),
    .close_pend (close_pend),
    .fifo_full  (fifo_full),
    .hold_q     (hold_w),
    .fifo_wr    (fifo_wr),
    .close_ack  (close_ack),
    .stall      (stall),
    .overflow   (overflow),
    .pend_cnt   (pend_cnt)
  );

  rxp_word_fifo #(.WORDS(WORDS)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .wr_en     (fifo_wr),
    .wdata     (hold_w),
    .rd_pop    (rd_pop),
    .rdata     (head_w),
    .not_empty (rd_valid),
    .full      (fifo_full)
  );

  assign rd_data   = head_w.data;
  assign rd_nbytes = head_w.nbytes;
  assign rd_last   = head_w.last;

  AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (close_pend && !stall && !flush && !sw_close) |=> !close_pend); // R5
endmodule

// File: tb/rx_word_packer_tb.sv
`timescale 1ns/1ps
module rx_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0, byte_valid = 1'b0, frame_end = 1'b0;
  logic        sw_close = 1'b0, flush = 1'b0, rd_pop = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        close_pend, rd_valid, rd_last, fifo_full, stall, overflow;
  logic [1:0]  pend_cnt;
  logic [31:0] rd_data;
  logic [2:0]  rd_nbytes;

  int checks = 0, failures = 0;
  logic [35:0] expq[$];
  logic [31:0] m_acc;
  int          m_n;
  int          seq = 0;

  always #2 clk = ~clk;

  rx_word_packer dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .byte_valid(byte_valid),
    .byte_data(byte_data), .frame_end(frame_end), .sw_close(sw_close),
    .flush(flush), .rd_pop(rd_pop), .close_pend(close_pend),
    .pend_cnt(pend_cnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_nbytes(rd_nbytes), .rd_last(rd_last), .fifo_full(fifo_full),
    .stall(stall), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [7:0] bval(input int i);
    return 8'(i * 29 + 7);
  endfunction

  task automatic model_close();
    if (m_n != 0) expq.push_back({1'b1, 3'(m_n), m_acc});
    m_acc = '0;
    m_n = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit eof, input bit model);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b; frame_end = eof;
    @(negedge clk);
    byte_valid = 1'b0; frame_end = 1'b0;
    if (model) begin
      m_acc[m_n*8 +: 8] = b;
      m_n++;
      if (eof) model_close();
      else if (m_n == 4) begin
        expq.push_back({1'b0, 3'd4, m_acc});
        m_acc = '0;
        m_n = 0;
      end
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    wait_cycles(3);
    while (rd_valid) begin
      logic [35:0] e;
      e = (expq.size() != 0) ? expq.pop_front() : 36'hF_FFFF_FFFF;
      chk({rd_last, rd_nbytes, rd_data} == e, req, {rd_last, rd_nbytes, rd_data}, e);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    chk(expq.size() == 0, {req, " leftover"}, 36'(expq.size()), 36'd0);
    expq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 36'd1, 36'd0);
    finish_run();
  end

  initial begin
    m_acc = '0; m_n = 0;
    wait_cycles(4);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk({pend_cnt, close_pend, rd_valid, fifo_full, stall, overflow} == '0, "R9",
        36'({pend_cnt, close_pend, rd_valid, fifo_full, stall, overflow}), 36'd0);

    // R1 disabled receiver ignores bytes and frame end
    for (int i = 0; i < 3; i++) send_byte(bval(i), i == 2, 1'b0);
    wait_cycles(3);
    chk(pend_cnt == 2'd0, "R1 pend", 36'(pend_cnt), 36'd0);
    chk(rd_valid == 1'b0, "R1 fifo", 36'(rd_valid), 36'd0);

    rx_en = 1'b1;
    // R2 R3 R4 sweep: frames of 1..9 bytes, closed with last byte or a separate pulse
    for (int mode = 0; mode < 2; mode++) begin
      for (int len = 1; len <= 9; len++) begin
        for (int i = 0; i < len; i++) begin
          send_byte(bval(seq), (mode == 0) && (i == len - 1), 1'b1);
          seq++;
          chk(pend_cnt == 2'(m_n), "R3 pend_cnt", 36'(pend_cnt), 36'(m_n));
        end
        if (mode == 1) begin
          @(negedge clk); frame_end = 1'b1;
          @(negedge clk); frame_end = 1'b0;
          model_close();
          chk(pend_cnt == 2'd0, "R4 pend after close", 36'(pend_cnt), 36'd0);
        end
        drain(mode == 0 ? "R2 R4 eof-with-byte" : "R2 R4 eof-alone");
      end
    end

    // R2 latency: word readable two edges after its fourth byte
    for (int i = 0; i < 4; i++) send_byte(bval(100 + i), 1'b0, 1'b1);
    chk(rd_valid == 1'b0, "R2 latency edge1", 36'(rd_valid), 36'd0);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R2 latency edge2", 36'(rd_valid), 36'd1);
    drain("R2 full word");

    // R5 software close with two pending bytes
    send_byte(8'hA1, 1'b0, 1'b1);
    send_byte(8'hB2, 1'b0, 1'b1);
    @(negedge clk); sw_close = 1'b1;
    @(negedge clk); sw_close = 1'b0;
    chk(close_pend == 1'b1, "R5 set", 36'(close_pend), 36'd1);
    @(negedge clk);
    chk(close_pend == 1'b0, "R5 self-clear", 36'(close_pend), 36'd0);
    chk(pend_cnt == 2'd0, "R5 pend", 36'(pend_cnt), 36'd0);
    model_close();
    drain("R5 partial close word");

    // R5 close with nothing pending writes nothing
    @(negedge clk); sw_close = 1'b1;
    @(negedge clk); sw_close = 1'b0;
    chk(close_pend == 1'b1, "R5 empty set", 36'(close_pend), 36'd1);
    @(negedge clk);
    chk(close_pend == 1'b0, "R5 empty clear", 36'(close_pend), 36'd0);
    wait_cycles(3);
    chk(rd_valid == 1'b0, "R5 empty no word", 36'(rd_valid), 36'd0);

    // R6 R7 fill FIFO (16 words) plus one held word, then overflow
    for (int i = 0; i < 68; i++) send_byte(bval(200 + i), 1'b0, 1'b1);
    wait_cycles(3);
    chk(fifo_full == 1'b1, "R6 full", 36'(fifo_full), 36'd1);
    chk(stall == 1'b1, "R7 stall", 36'(stall), 36'd1);
    chk(overflow == 1'b0, "R7 no overflow yet", 36'(overflow), 36'd0);
    send_byte(8'h5A, 1'b0, 1'b0);
    chk(overflow == 1'b1, "R7 overflow", 36'(overflow), 36'd1);
    chk(pend_cnt == 2'd0, "R7 dropped byte", 36'(pend_cnt), 36'd0);
    drain("R6 R7 fifo order");
    chk(stall == 1'b0, "R7 stall released", 36'(stall), 36'd0);
    chk(overflow == 1'b1, "R7 sticky", 36'(overflow), 36'd1);

    // R8 flush
    send_byte(8'h11, 1'b0, 1'b0);
    send_byte(8'h22, 1'b0, 1'b0);
    send_byte(8'h33, 1'b0, 1'b0);
    send_byte(8'h44, 1'b0, 1'b0);
    send_byte(8'h55, 1'b0, 1'b0);
    wait_cycles(2);
    @(negedge clk); sw_close = 1'b1; flush = 1'b1;
    @(negedge clk); sw_close = 1'b0;
    chk(rd_valid == 1'b0, "R8 empty", 36'(rd_valid), 36'd0);
    chk(pend_cnt == 2'd0, "R8 pend", 36'(pend_cnt), 36'd0);
    chk(overflow == 1'b0, "R8 overflow", 36'(overflow), 36'd0);
    chk(close_pend == 1'b0, "R8 close", 36'(close_pend), 36'd0);
    send_byte(8'h66, 1'b0, 1'b0);
    chk(pend_cnt == 2'd0, "R8 ignore byte", 36'(pend_cnt), 36'd0);
    @(negedge clk); flush = 1'b0;
    m_acc = '0; m_n = 0;
    send_byte(8'h77, 1'b1, 1'b1);
    drain("R8 after flush");

    finish_run();
  end
endmodule